// File: doc/BRIEF.md
# Privileged Control Register Write Guard

This block holds three privileged control registers (the address-space/region register, the processor status register and the exception cause register) and performs every software write to them through a write mask. The mask is built for each write. It starts from a fixed base mask of writable bits. The region register mask is also limited by a segment mask that covers only the implemented virtual address bits.

When the newer-release mode input is high, the block narrows the mask further. The narrowing depends on the data being written and on the value already stored. A reserved region encoding is refused, and a privilege-mode field that holds the reserved value 3 is frozen. Status and cause bits that only hardware may set can be cleared by software but never set by it. In legacy mode only the base masks and the segment mask apply.

A single write port with a register select updates at most one register per clock edge.

Top module: `priv_wr_guard`

## Requirements
- R1: On reset, the region output equals REGION_RST, the status output equals STATUS_RST and the cause output equals CAUSE_RST.
- R2: A write with wr_sel_i = 0 (region), 1 (status) or 2 (cause) sets that register to (old AND NOT mask) OR (data AND mask) on the next rising clock edge. The other two registers keep their values. Select value 3 writes nothing.
- R3: In newer-release mode, a region write whose data bits 63:62 equal 2 leaves stored bits 63:62 unchanged. The other masked bits are still written.
- R4: In newer-release mode, a region write whose data bits 63:62 equal 1 leaves stored bits 63:62 unchanged in either of two cases: bit 3 of STATUS_BASE_MASK is 0 (no supervisor mode), or cfg_arch_i equals 1. Otherwise the value 1 is written.
- R5: A region write changes only the bits that are set in both REGION_BASE_MASK and seg_mask_i.
- R6: In newer-release mode, if the stored status bits 4:3 hold 3, a status write leaves bits 4:3 unchanged.
- R7: In newer-release mode, a status write can clear bits 20:19 but cannot set them. A 1 in the data leaves the stored bit as it was.
- R8: In newer-release mode, a cause write can clear bit 22 but cannot set it.
- R9: In legacy mode, none of the restrictions in R3, R4, R6, R7 or R8 apply. The mask is the base mask, ANDed with seg_mask_i for the region register.
- R10: When wr_en_i is low, no register changes, whatever the other inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Target: 0 region, 1 status, 2 cause, 3 none |
| wr_data_i | input | 64 | Write data; status and cause use bits 31:0 |
| new_mode_i | input | 1 | Newer-release restrictions enable |
| cfg_arch_i | input | 2 | Architecture-type configuration field |
| seg_mask_i | input | 64 | Implemented virtual address bits |
| region_o | output | 64 | Stored region register |
| status_o | output | 32 | Stored status register |
| cause_o | output | 32 | Stored cause register |

## Verification
Each register is updated on the first rising edge after a write is presented, so every result is due exactly one cycle after its stimulus. The bench drives inputs just after a falling edge. It compares all three outputs with its model at the next falling edge, after the updating rising edge and before any further write. Tests for an ignored write (R10, select 3, and the blocked bits in R3, R4, R6, R7 and R8) are read at that same point. Any unwanted change would show there.

// File: rtl/priv_wr_pkg.sv
package priv_wr_pkg;
  localparam int unsigned REG_W = 64;
  localparam int unsigned CTL_W = 32;

  typedef enum logic [1:0] {
    SEL_REGION = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_CAUSE  = 2'd2,
    SEL_NONE   = 2'd3
  } wr_sel_e;

  localparam int unsigned RGN_LO    = 62;
  localparam int unsigned KSU_LO    = 3;
  localparam int unsigned STICKY_LO = 19;
  localparam int unsigned WP_BIT    = 22;
  localparam int unsigned SUP_BIT   = 3;

  localparam logic [1:0] RGN_RSVD = 2'd2;
  localparam logic [1:0] RGN_SUP  = 2'd1;
  localparam logic [1:0] KSU_RSVD = 2'd3;
  localparam logic [1:0] ARCH_SEG = 2'd1;
endpackage

// File: rtl/region_mask_gen.sv
module region_mask_gen
  import priv_wr_pkg::*;
#(
  parameter logic [REG_W-1:0] BASE_MASK = '1,
  parameter bit               HAS_SUP   = 1'b1
) (
  input  logic             new_mode_i,
  input  logic [1:0]       rgn_i,
  input  logic [1:0]       arch_i,
  input  logic [REG_W-1:0] seg_mask_i,
  output logic [REG_W-1:0] mask_o
);
  logic rsvd;

  always_comb begin
    rsvd = (rgn_i == RGN_RSVD) ||
           ((rgn_i == RGN_SUP) && (!HAS_SUP || arch_i == ARCH_SEG));
    mask_o = BASE_MASK & seg_mask_i;
    if (new_mode_i && rsvd) mask_o[RGN_LO +: 2] = 2'b00;
  end
endmodule

// File: rtl/status_mask_gen.sv
module status_mask_gen
  import priv_wr_pkg::*;
#(
  parameter logic [CTL_W-1:0] BASE_MASK = '1
) (
  input  logic             new_mode_i,
  input  logic [CTL_W-1:0] cur_i,
  input  logic [CTL_W-1:0] data_i,
  output logic [CTL_W-1:0] mask_o
);
  always_comb begin
    mask_o = BASE_MASK;
    if (new_mode_i) begin
      if (cur_i[KSU_LO +: 2] == KSU_RSVD) mask_o[KSU_LO +: 2] = 2'b00;
      // set-only-by-hardware bits: a 1 in data drops the bit from the mask
      mask_o[STICKY_LO +: 2] = mask_o[STICKY_LO +: 2] & ~data_i[STICKY_LO +: 2];
    end
  end
endmodule

// File: rtl/cause_mask_gen.sv
module cause_mask_gen
  import priv_wr_pkg::*;
#(
  parameter logic [CTL_W-1:0] BASE_MASK = '1
) (
  input  logic             new_mode_i,
  input  logic             wp_i,
  output logic [CTL_W-1:0] mask_o
);
  always_comb begin
    mask_o = BASE_MASK;
    if (new_mode_i && wp_i) mask_o[WP_BIT] = 1'b0;
  end
endmodule

// File: rtl/masked_reg.sv
module masked_reg #(
  parameter int unsigned W   = 32,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST;
    else if (we_i) q_o <= (q_o & ~mask_i) | (data_i & mask_i);
  end
endmodule

// File: rtl/priv_wr_guard.sv
module priv_wr_guard
  import priv_wr_pkg::*;
#(
  parameter logic [REG_W-1:0] REGION_BASE_MASK = 64'hC000_00FF_FFFF_E0FF,
  parameter logic [CTL_W-1:0] STATUS_BASE_MASK = 32'h3058_FF1F,
  parameter logic [CTL_W-1:0] CAUSE_BASE_MASK  = 32'h08C0_0300,
  parameter logic [REG_W-1:0] REGION_RST       = '0,
  parameter logic [CTL_W-1:0] STATUS_RST       = 32'h0040_0004,
  parameter logic [CTL_W-1:0] CAUSE_RST        = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             new_mode_i,
  input  logic [1:0]       cfg_arch_i,
  input  logic [REG_W-1:0] seg_mask_i,
  output logic [REG_W-1:0] region_o,
  output logic [CTL_W-1:0] status_o,
  output logic [CTL_W-1:0] cause_o
);
  localparam bit HAS_SUP = STATUS_BASE_MASK[SUP_BIT];

  wr_sel_e          sel;
  logic [REG_W-1:0] rgn_mask;
  logic [CTL_W-1:0] st_mask, ca_mask, data_lo;
  logic [2:0]       we;

  assign sel     = wr_sel_e'(wr_sel_i);
  assign data_lo = wr_data_i[CTL_W-1:0];

  always_comb begin
    we = 3'b000;
    if (wr_en_i) begin
      unique case (sel)
        SEL_REGION: we[0] = 1'b1;
        SEL_STATUS: we[1] = 1'b1;
        SEL_CAUSE:  we[2] = 1'b1;
        default:    we    = 3'b000;
      endcase
    end
  end

  region_mask_gen #(.BASE_MASK(REGION_BASE_MASK), .HAS_SUP(HAS_SUP)) u_rgn_mask (
    .new_mode_i (new_mode_i),
    .rgn_i      (wr_data_i[RGN_LO +: 2]),
    .arch_i     (cfg_arch_i),
    .seg_mask_i (seg_mask_i),
    .mask_o     (rgn_mask)
  );

  status_mask_gen #(.BASE_MASK(STATUS_BASE_MASK)) u_st_mask (
    .new_mode_i (new_mode_i),
    .cur_i      (status_o),
    .data_i     (data_lo),
    .mask_o     (st_mask)
  );

  cause_mask_gen #(.BASE_MASK(CAUSE_BASE_MASK)) u_ca_mask (
    .new_mode_i (new_mode_i),
    .wp_i       (data_lo[WP_BIT]),
    .mask_o     (ca_mask)
  );

  masked_reg #(.W(REG_W), .RST(REGION_RST)) u_rgn (
    .clk_i, .rst_ni, .we_i(we[0]), .mask_i(rgn_mask), .data_i(wr_data_i), .q_o(region_o)
  );
  masked_reg #(.W(CTL_W), .RST(STATUS_RST)) u_st (
    .clk_i, .rst_ni, .we_i(we[1]), .mask_i(st_mask), .data_i(data_lo), .q_o(status_o)
  );
  masked_reg #(.W(CTL_W), .RST(CAUSE_RST)) u_ca (
    .clk_i, .rst_ni, .we_i(we[2]), .mask_i(ca_mask), .data_i(data_lo), .q_o(cause_o)
  );

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(region_o) && $stable(status_o) && $stable(cause_o))); // R10
  AST_SEL_ISOLATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sel_i != SEL_STATUS) |=> $stable(status_o)); // R2
  AST_RGN_RSVD_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && new_mode_i && wr_sel_i == SEL_REGION && wr_data_i[63:62] == 2'd2)
    |=> $stable(region_o[63:62])); // R3
  AST_KSU_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (new_mode_i && status_o[4:3] == 2'd3) |=> (status_o[4:3] == 2'd3)); // R6
  AST_STICKY_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && new_mode_i && wr_sel_i == SEL_STATUS && status_o[20:19] == 2'b00)
    |=> (status_o[20:19] == 2'b00)); // R7
  AST_WP_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && new_mode_i && wr_sel_i == SEL_CAUSE && !cause_o[22])
    |=> !cause_o[22]); // R8
endmodule

// File: tb/sim_priv_wr_guard.sv
module sim_priv_wr_guard;
  localparam logic [63:0] RB   = 64'hC000_00FF_FFFF_E0FF;
  localparam logic [31:0] SB   = 32'h3058_FF1F;
  localparam logic [31:0] SB_N = 32'h3058_FF17;
  localparam logic [31:0] CB   = 32'h08C0_0300;
  localparam logic [31:0] ST_R = 32'h0040_0004;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, nm = 1'b0;
  logic [1:0] sel = 2'd3, arch = 2'd0;
  logic [63:0] data = '0, seg = '1;
  logic [63:0] rg0, rg1;
  logic [31:0] st0, st1, ca0, ca1;
  int total = 0, bad = 0;

  logic [63:0] m_rg [2];
  logic [31:0] m_st [2], m_ca [2];

  always #5 clk = ~clk;

  priv_wr_guard u0 (.clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .wr_sel_i(sel),
    .wr_data_i(data), .new_mode_i(nm), .cfg_arch_i(arch), .seg_mask_i(seg),
    .region_o(rg0), .status_o(st0), .cause_o(ca0));
  priv_wr_guard #(.STATUS_BASE_MASK(SB_N)) u1 (.clk_i(clk), .rst_ni(rst_n), .wr_en_i(we),
    .wr_sel_i(sel), .wr_data_i(data), .new_mode_i(nm), .cfg_arch_i(arch), .seg_mask_i(seg),
    .region_o(rg1), .status_o(st1), .cause_o(ca1));

  function automatic logic [63:0] f_rmask(logic n, logic [63:0] d, logic [1:0] a,
                                          logic [63:0] s, logic sup);
    logic [63:0] m = RB & s;
    if (n && (d[63:62] == 2'd2 || (d[63:62] == 2'd1 && (!sup || a == 2'd1)))) m[63:62] = 2'b00;
    return m;
  endfunction
  function automatic logic [31:0] f_smask(logic n, logic [31:0] cur, logic [31:0] d, logic [31:0] b);
    logic [31:0] m = b;
    if (n) begin
      if (cur[4:3] == 2'd3) m[4:3] = 2'b00;
      m = m & ~(d & 32'h0018_0000);
    end
    return m;
  endfunction
  function automatic logic [31:0] f_cmask(logic n, logic [31:0] d);
    logic [31:0] m = CB;
    if (n && d[22]) m[22] = 1'b0;
    return m;
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk(tag, rg0, m_rg[0]); chk(tag, {32'h0, st0}, {32'h0, m_st[0]});
    chk(tag, {32'h0, ca0}, {32'h0, m_ca[0]});
    chk(tag, rg1, m_rg[1]); chk(tag, {32'h0, st1}, {32'h0, m_st[1]});
    chk(tag, {32'h0, ca1}, {32'h0, m_ca[1]});
  endtask

  // drive just after negedge, update model, sample at next negedge
  task automatic wr(logic e, logic [1:0] s, logic [63:0] d, logic n, logic [1:0] a,
                    logic [63:0] sg, string tag);
    we = e; sel = s; data = d; nm = n; arch = a; seg = sg;
    for (int i = 0; i < 2; i++) begin
      logic [63:0] rm;
      logic [31:0] sm, cm;
      rm = f_rmask(n, d, a, sg, i == 0);
      sm = f_smask(n, m_st[i], d[31:0], i == 0 ? SB : SB_N);
      cm = f_cmask(n, d[31:0]);
      if (e && s == 2'd0) m_rg[i] = (m_rg[i] & ~rm) | (d & rm);
      if (e && s == 2'd1) m_st[i] = (m_st[i] & ~sm) | (d[31:0] & sm);
      if (e && s == 2'd2) m_ca[i] = (m_ca[i] & ~cm) | (d[31:0] & cm);
    end
    @(negedge clk);
    we = 1'b0;
    chk_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog got=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 2; i++) begin m_rg[i] = '0; m_st[i] = ST_R; m_ca[i] = '0; end
    repeat (3) @(negedge clk);
    chk_all("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R3: reserved region 2 blocked, low bits still written
    wr(1, 0, 64'h8000_0000_0000_00AB, 1, 0, '1, "R3 rsvd region");
    chk("R3 region bits", {62'h0, rg0[63:62]}, 64'h0);
    chk("R3 low bits", {56'h0, rg0[7:0]}, 64'hAB);
    // R4: region 1
    wr(1, 0, 64'h4000_0000_0000_0001, 1, 0, '1, "R4 sup arch0");
    chk("R4 written", {62'h0, rg0[63:62]}, 64'h1);
    chk("R4 no-sup blocked", {62'h0, rg1[63:62]}, 64'h0);
    wr(1, 0, 64'h0000_0000_0000_0002, 1, 0, '1, "R4 clear");
    wr(1, 0, 64'h4000_0000_0000_0003, 1, 1, '1, "R4 arch1 blocked");
    chk("R4 arch1", {62'h0, rg0[63:62]}, 64'h0);
    // R9: legacy allows region 2
    wr(1, 0, 64'h8000_0000_0000_0000, 0, 1, '1, "R9 legacy region");
    chk("R9 region2", {62'h0, rg0[63:62]}, 64'h2);
    // R5: segment mask
    wr(1, 0, 64'h0, 0, 0, '1, "R5 clear");
    wr(1, 0, '1, 0, 0, 64'h0000_00FF_FFFF_FFFF, "R5 seg");
    chk("R5 seg value", rg0, 64'h0000_00FF_FFFF_E0FF);
    // R6: KSU lock
    wr(1, 1, 64'h18, 1, 0, '1, "R6 set ksu3");
    wr(1, 1, 64'h00, 1, 0, '1, "R6 locked");
    chk("R6 ksu held", {62'h0, st0[4:3]}, 64'h3);
    wr(1, 1, 64'h00, 0, 0, '1, "R9 legacy ksu clear");
    chk("R9 ksu cleared", {62'h0, st0[4:3]}, 64'h0);
    // R7: sticky status bits
    wr(1, 1, 64'h0018_0000, 0, 0, '1, "R7 legacy set");
    chk("R7 set legacy", {62'h0, st0[20:19]}, 64'h3);
    wr(1, 1, 64'h0, 1, 0, '1, "R7 clear");
    chk("R7 cleared", {62'h0, st0[20:19]}, 64'h0);
    wr(1, 1, 64'h0018_0000, 1, 0, '1, "R7 no set");
    chk("R7 not set", {62'h0, st0[20:19]}, 64'h0);
    // R8: cause watch-pending
    wr(1, 2, 64'h0040_0000, 1, 0, '1, "R8 no set");
    chk("R8 not set", {63'h0, ca0[22]}, 64'h0);
    wr(1, 2, 64'h0040_0000, 0, 0, '1, "R8 legacy set");
    wr(1, 2, 64'h0, 1, 0, '1, "R8 clear");
    chk("R8 cleared", {63'h0, ca0[22]}, 64'h0);
    // R10 and select 3
    wr(0, 1, '1, 0, 0, '1, "R10 idle");
    wr(1, 3, '1, 0, 0, '1, "R2 sel none");

    for (int n = 0; n < 3000; n++) begin
      logic [63:0] d;
      logic [63:0] sg;
      d = {$urandom, $urandom};
      sg = ($urandom_range(0, 3) == 0) ? 64'h0000_00FF_FFFF_FFFF : '1;
      wr($urandom_range(0, 7) != 0, 2'($urandom_range(0, 3)), d, 1'($urandom),
         2'($urandom_range(0, 3)), sg, "R2 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule